// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block takes configuration from a three-wire synchronous serial bus (a serial clock, a data line and a strobe) and turns it into four parallel configuration words. Bits arrive most significant first and are taken on each rising edge of the serial clock. They collect in a 22-bit frame register, and that register always holds the most recent 22 bits.

A rising edge on the strobe commits the frame. The two lowest frame bits pick one of four words, and the upper twenty bits become that word's new value. The other three words keep their values. Setup words can be written once after power-up, and frequently changed words, such as a channel setting, can be rewritten as often as needed.

All three bus wires are asynchronous to the system clock. Each one passes through a synchronizer, and edges are detected in the system clock domain. The bus can run at 20 Mbit/s when each serial clock phase lasts at least three system clock cycles. Reset clears every word to zero, which is the all-off configuration.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is asserted and after it is released, all four words on `cfg_words` read zero until the first strobe commit.
- R2: A data bit is taken only on a rising edge of `ser_clk`, and the first bit is the frame MSB (frame bit 21). Changes on `ser_data` while `ser_clk` is high or falling have no effect. Each serial clock phase must last at least 3 system clock cycles.
- R3: The frame register holds exactly the last 22 bits shifted in. Extra leading bits are pushed out. A strobe with no new bits commits the previous frame contents again.
- R4: Frame bits [1:0] are the word address. Word k occupies `cfg_words[k*20 +: 20]` for k = 0..3.
- R5: On a commit, the addressed word takes frame bits [21:2], with frame bit 21 landing in word bit 19.
- R6: A commit changes exactly the addressed word. The other three words keep their values.
- R7: The words change only on a rising edge of `ser_strobe`. Shifting bits, holding the strobe high, or its falling edge leave all words unchanged.
- R8: After `ser_strobe` rises between two system clock edges, the new word value appears after the third rising `clk` edge (SYNC_STAGES+1) and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bus clock, asynchronous |
| ser_data | input | 1 | Serial bus data, MSB first |
| ser_strobe | input | 1 | Serial bus strobe; its rising edge commits the frame |
| cfg_words | output | 80 | Four 20-bit words, word k at bits [k*20 +: 20] |

## Verification
The hardest condition to reach is a commit that must not happen. This covers a strobe held high while a whole new frame shifts in, data that toggles during the high phase of the serial clock, and a strobe that arrives with an overlong or missing frame. The driver task flips the data line after every rising serial clock edge, so every frame also exercises the falling-edge case. Separate sequences prefix junk bits, strobe twice without shifting, and shift a full frame under a held strobe. The monitor checks each commit one cycle before and one cycle after its expected edge, so the three-edge latency is pinned from both sides.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int FRAME_W_DEF     = 22;
  localparam int ADDR_W_DEF      = 2;
  localparam int SYNC_STAGES_DEF = 2;

  // rising-edge detect of a sampled level against its previous value
  function automatic logic level_rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge
  import cfg_loader_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= '0;
    else        lvl_d <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = level_rise(lvl[i], lvl_d[i]);
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int FRAME_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame_q
);
  function automatic logic [FRAME_W-1:0] push_lsb(input logic [FRAME_W-1:0] cur,
                                                  input logic b);
    return {cur[FRAME_W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame_q <= '0;
    else if (shift_en) frame_q <= push_lsb(frame_q, bit_in);
  end
endmodule

// File: rtl/cfg_wordbank.sv
module cfg_wordbank #(
  parameter int FRAME_W   = 22,
  parameter int ADDR_W    = 2,
  localparam int PAYLOAD_W = FRAME_W - ADDR_W,
  localparam int NUM_WORDS = 1 << ADDR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit,
  input  logic [FRAME_W-1:0]             frame,
  output logic [NUM_WORDS-1:0]           wr_en,
  output logic [NUM_WORDS*PAYLOAD_W-1:0] words
);
  function automatic logic [NUM_WORDS-1:0] decode(input logic [ADDR_W-1:0] a,
                                                  input logic en);
    logic [NUM_WORDS-1:0] v;
    v = '0;
    v[a] = en;
    return v;
  endfunction

  logic [ADDR_W-1:0]    addr_f;
  logic [PAYLOAD_W-1:0] payload_f;

  assign addr_f    = frame[ADDR_W-1:0];
  assign payload_f = frame[FRAME_W-1:ADDR_W];
  assign wr_en     = decode(addr_f, commit);

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        words[k*PAYLOAD_W +: PAYLOAD_W] <= '0;
      else if (wr_en[k]) words[k*PAYLOAD_W +: PAYLOAD_W] <= payload_f;
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_W     = FRAME_W_DEF,
  parameter int ADDR_W      = ADDR_W_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF,
  localparam int PAYLOAD_W  = FRAME_W - ADDR_W,
  localparam int NUM_WORDS  = 1 << ADDR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ser_clk,
  input  logic                           ser_data,
  input  logic                           ser_strobe,
  output logic [NUM_WORDS*PAYLOAD_W-1:0] cfg_words
);
  logic [2:0]           bus_s;
  logic                 data_s;
  logic [1:0]           edges;
  logic                 sclk_rise;
  logic                 strobe_rise;
  logic [FRAME_W-1:0]   shift_q;
  logic [NUM_WORDS-1:0] wr_en;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_strobe, ser_clk, ser_data}),
    .dout (bus_s)
  );

  assign data_s = bus_s[0];

  cfg_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (bus_s[2:1]),
    .rise (edges)
  );

  assign sclk_rise   = edges[0];
  assign strobe_rise = edges[1];

  cfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(sclk_rise),
    .bit_in  (data_s),
    .frame_q (shift_q)
  );

  cfg_wordbank #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .commit(strobe_rise),
    .frame (shift_q),
    .wr_en (wr_en),
    .words (cfg_words)
  );
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk #(
  parameter int FRAME_W  = 22,
  parameter int ADDR_W   = 2,
  localparam int PAYLOAD_W = FRAME_W - ADDR_W,
  localparam int NUM_WORDS = 1 << ADDR_W
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           sclk_rise,
  input logic                           strobe_rise,
  input logic                           data_s,
  input logic [FRAME_W-1:0]             shift_q,
  input logic [NUM_WORDS-1:0]           wr_en,
  input logic [NUM_WORDS*PAYLOAD_W-1:0] cfg_words
);
  logic [ADDR_W-1:0]    last_addr;
  logic [PAYLOAD_W-1:0] sel_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_addr <= '0;
    else        last_addr <= shift_q[ADDR_W-1:0];
  end

  assign sel_word = cfg_words[last_addr*PAYLOAD_W +: PAYLOAD_W];

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> cfg_words == '0);  // R1
  AST_SHIFT_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shift_q[0] == $past(data_s));  // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(shift_q));  // R3
  AST_PAYLOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> sel_word == $past(shift_q[FRAME_W-1:ADDR_W]));  // R5
  AST_SINGLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));  // R6
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_rise |=> $stable(cfg_words));  // R7
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_rise  (sclk_rise),
  .strobe_rise(strobe_rise),
  .data_s     (data_s),
  .shift_q    (shift_q),
  .wr_en      (wr_en),
  .cfg_words  (cfg_words)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  localparam int PW = 20;
  localparam int NW = 4;

  typedef struct {
    int            addr;
    logic [PW-1:0] payload;
  } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic ser_clk = 0;
  logic ser_data = 0;
  logic ser_strobe = 0;
  logic [NW*PW-1:0] cfg_words;

  int n_checks = 0;
  int n_fail = 0;
  logic [PW-1:0] model [NW];
  item_t exp_q [$];
  bit done = 0;

  always #2 clk = ~clk;

  serial_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .cfg_words(cfg_words)
  );

  function automatic logic [NW*PW-1:0] packed_model();
    logic [NW*PW-1:0] v;
    for (int k = 0; k < NW; k++) v[k*PW +: PW] = model[k];
    return v;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [NW*PW-1:0] act, input logic [NW*PW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit, MSB-first order is up to the caller; data flipped while clock high (R2)
  task automatic send_bit(input logic b);
    ser_data = b;
    wait_cyc(3);
    ser_clk = 1;
    wait_cyc(3);
    ser_data = ~b;
    wait_cyc(1);
    ser_clk = 0;
    wait_cyc(2);
  endtask

  task automatic shift_frame(input int addr, input logic [PW-1:0] payload);
    logic [PW+1:0] f;
    f = {payload, addr[1:0]};
    for (int i = PW + 1; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_strobe();
    wait_cyc(3);
    ser_strobe = 1;
    wait_cyc(8);
    ser_strobe = 0;
    wait_cyc(4);
  endtask

  task automatic write_word(input int addr, input logic [PW-1:0] payload);
    item_t it;
    it.addr = addr;
    it.payload = payload;
    exp_q.push_back(it);
    shift_frame(addr, payload);
    pulse_strobe();
  endtask

  // monitor: on every strobe rise, check old value after 2 edges, new after 3 (R8)
  initial begin
    forever begin
      @(posedge ser_strobe);
      if (exp_q.size() > 0) begin
        item_t it;
        logic [NW*PW-1:0] e;
        repeat (2) @(posedge clk);
        @(negedge clk);
        e = packed_model();
        check(cfg_words === e, "R8 early", cfg_words, e);
        @(posedge clk);
        @(negedge clk);
        it = exp_q.pop_front();
        model[it.addr] = it.payload;
        e = packed_model();
        check(cfg_words === e, "R4/R5/R6 commit", cfg_words, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NW*PW-1:0] e;
    for (int k = 0; k < NW; k++) model[k] = '0;
    wait_cyc(2);
    check(cfg_words === '0, "R1 in reset", cfg_words, '0);
    rst_n = 1;
    wait_cyc(5);
    check(cfg_words === '0, "R1 after reset", cfg_words, '0);

    // R4 R5: all four addresses with distinct patterns
    write_word(0, 20'hA5A5A);
    write_word(1, 20'hFFFFF);
    write_word(2, 20'h80001);
    write_word(3, 20'h12345);
    // dynamic rewrite of one word, others held (R6)
    write_word(2, 20'h55555);
    write_word(2, 20'h00000);

    // R7: shifting a frame without strobe changes nothing
    shift_frame(1, 20'h0F0F0);
    wait_cyc(8);
    e = packed_model();
    check(cfg_words === e, "R7 shift only", cfg_words, e);
    // R3: strobe with no new bits recommits that frame
    begin
      item_t it;
      it.addr = 1; it.payload = 20'h0F0F0;
      exp_q.push_back(it);
      pulse_strobe();
    end

    // R3: overlong frame, leading junk bits pushed out
    begin
      item_t it;
      it.addr = 3; it.payload = 20'hC3C3C;
      exp_q.push_back(it);
      send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
      shift_frame(3, 20'hC3C3C);
      pulse_strobe();
    end

    // R7: strobe held high while a new frame shifts, then falls: no write
    wait_cyc(3);
    ser_strobe = 1;
    wait_cyc(8);
    shift_frame(0, 20'h13579);
    wait_cyc(8);
    ser_strobe = 0;
    wait_cyc(8);
    e = packed_model();
    check(cfg_words === e, "R7 held/falling strobe", cfg_words, e);
    // the held frame still commits on a later rise (R2 bit order)
    begin
      item_t it;
      it.addr = 0; it.payload = 20'h13579;
      exp_q.push_back(it);
      pulse_strobe();
    end

    wait (exp_q.size() == 0);
    wait_cyc(6);
    e = packed_model();
    check(cfg_words === e, "R6 final", cfg_words, e);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule